// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block conditions eight active-low interrupt pins coming from outside the chip and turns them into a vector of request lines for a downstream priority resolver. Each pin can be set to one of two senses. In level-low sense it requests for as long as it is held low. In falling-edge sense a high-to-low transition is captured in a pending flag, and that flag holds until software clears it. No high-level or rising-edge sense exists.

Every pin passes through a two-flop synchronizer. A falling edge is a synchronized one followed by a synchronized zero. A small register port gives access to three words: sense selection, enable mask and acknowledge. Writing a one to the acknowledge word clears an edge-pending flag. Reading that word returns the raw, unmasked pending state of each pin.

Pin 0 can be diverted to a separate machine-check request line instead of the normal request vector. After reset every source is blocked.

Top module: `xirq_sense_unit`

## Requirements
- R1: After reset, req_o and mc_req_o are 0, and the sense word (address 0) and the mask word (address 1) both read 0, so every pin is level-low and blocked.
- R2: In the sense word, pin k is selected by bit 15-k (pin 0 uses bit 15, pin 7 uses bit 8). A 1 selects falling-edge sense and a 0 selects level-low sense. All other bits read 0.
- R3: In the mask and acknowledge words, pin b corresponds to bit 31-b. A set mask bit enables the pin and a clear one blocks it.
- R4: In level-low sense, an enabled pin held low drives its req_o bit to 1 within 4 cycles. The bit returns to 0 within 4 cycles of the pin going high.
- R5: In falling-edge sense, a high-to-low transition sets a pending flag that stays set after the pin returns high. A low-to-high transition never sets it.
- R6: Writing 1 to bit 31-b of the acknowledge word (address 2) clears pin b's edge-pending flag. Writing 0 to that bit leaves the flag unchanged. Reading address 2 returns each pin's unmasked pending state at bit 31-b.
- R7: In level-low sense, acknowledge writes have no effect: the request stays asserted while the pin is low.
- R8: A clear mask bit blocks the req_o bit but keeps the pending flag. The flag stays visible on read, and req_o rises once the mask bit is set.
- R9: A falling edge detected in the same cycle as an acknowledge of that pin leaves the pending flag set.
- R10: When bit 0 of the mask word is set, pin 0's enabled request appears on mc_req_o and req_o[0] stays 0. When the bit is clear, mc_req_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 8 | Asynchronous active-low interrupt pins |
| reg_addr | input | 2 | Word select: 0 sense, 1 mask, 2 acknowledge/status |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| req_o | output | 8 | Masked pending requests, one per pin |
| mc_req_o | output | 1 | Machine-check request from pin 0 when routed |

## Verification
The bench holds a pin low in level sense. This checks that the request follows the pin, and that acknowledges cannot clear it.

It also pulses a pin in edge sense. This separates a latched flag from a followed level. A low-to-high transition is then made after a mode switch, which shows that only falling edges are captured.

An acknowledge is timed to land in the very cycle a new falling edge is detected. This separates "set wins" from "clear wins".

Masked and routed cases show that gating and diversion act on the output only. The pending state stays visible through the status read.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SENSE_MSB = 15;
  localparam int unsigned ROUTE_POS = 0;

  typedef enum logic [1:0] {
    ADDR_SENSE = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_ACK   = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  // pin k sense select sits at a reversed position below bit 15
  function automatic int unsigned sense_pos(input int unsigned pin);
    return SENSE_MSB - pin;
  endfunction

  // big-endian source numbering for mask and acknowledge words
  function automatic int unsigned be_pos(input int unsigned pin);
    return WORD_W - 1 - pin;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/xirq_edge_cell.sv
module xirq_edge_cell (
  input  logic clk,
  input  logic rst,
  input  logic sync_lvl,
  input  logic edge_mode,
  input  logic ack_clr,
  output logic fall,
  output logic pend_q,
  output logic raw_req
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_lvl;
  end

  assign fall = prev_q & ~sync_lvl;

  always_ff @(posedge clk) begin
    if (rst || !edge_mode) pend_q <= 1'b0;
    else                   pend_q <= fall | (pend_q & ~ack_clr);
  end

  assign raw_req = edge_mode ? pend_q : ~sync_lvl;
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  localparam int unsigned AW = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       reg_addr,
  input  logic                reg_we,
  input  logic [WORD_W-1:0]   reg_wdata,
  input  logic [NUM_PINS-1:0] status_vec,
  output logic [NUM_PINS-1:0] edge_vec,
  output logic [NUM_PINS-1:0] mask_vec,
  output logic                route_q,
  output logic [NUM_PINS-1:0] ack_clr,
  output logic [WORD_W-1:0]   reg_rdata
);
  logic wr_sense, wr_mask, wr_ack;
  logic [WORD_W-1:0] rd_mux;
  logic unused_wbits;

  assign wr_sense = reg_we && (reg_addr == ADDR_SENSE);
  assign wr_mask  = reg_we && (reg_addr == ADDR_MASK);
  assign wr_ack   = reg_we && (reg_addr == ADDR_ACK);
  assign unused_wbits = ^reg_wdata;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        edge_vec[k] <= 1'b0;
        mask_vec[k] <= 1'b0;
      end else begin
        if (wr_sense) edge_vec[k] <= reg_wdata[sense_pos(k)];
        if (wr_mask)  mask_vec[k] <= reg_wdata[be_pos(k)];
      end
    end
    assign ack_clr[k] = wr_ack & reg_wdata[be_pos(k)];
  end

  always_ff @(posedge clk) begin
    if (rst)          route_q <= 1'b0;
    else if (wr_mask) route_q <= reg_wdata[ROUTE_POS];
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_SENSE: for (int k = 0; k < NUM_PINS; k++) rd_mux[sense_pos(k)] = edge_vec[k];
      ADDR_MASK: begin
        for (int k = 0; k < NUM_PINS; k++) rd_mux[be_pos(k)] = mask_vec[k];
        rd_mux[ROUTE_POS] = route_q;
      end
      ADDR_ACK:   for (int k = 0; k < NUM_PINS; k++) rd_mux[be_pos(k)] = status_vec[k];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/xirq_sense_unit.sv
module xirq_sense_unit
  import xirq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_n,
  input  logic [1:0]          reg_addr,
  input  logic                reg_we,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic [NUM_PINS-1:0] req_o,
  output logic                mc_req_o
);
  logic [NUM_PINS-1:0] sync_lvl, edge_vec, mask_vec, ack_clr;
  logic [NUM_PINS-1:0] fall_vec, pend_vec, raw_vec, gated;
  logic route_q;

  xirq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_n), .dout(sync_lvl)
  );

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_cell
    xirq_edge_cell u_cell (
      .clk(clk), .rst(rst), .sync_lvl(sync_lvl[k]), .edge_mode(edge_vec[k]),
      .ack_clr(ack_clr[k]), .fall(fall_vec[k]), .pend_q(pend_vec[k]),
      .raw_req(raw_vec[k])
    );
  end

  xirq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .status_vec(raw_vec), .edge_vec(edge_vec),
    .mask_vec(mask_vec), .route_q(route_q), .ack_clr(ack_clr),
    .reg_rdata(reg_rdata)
  );

  assign gated = raw_vec & mask_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o    <= '0;
      mc_req_o <= 1'b0;
    end else begin
      req_o    <= gated & ~{{(NUM_PINS-1){1'b0}}, route_q};
      mc_req_o <= gated[0] & route_q;
    end
  end
endmodule

// File: rtl/xirq_sense_chk.sv
module xirq_sense_chk #(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] req_o,
  input logic                mc_req_o,
  input logic [NUM_PINS-1:0] mask_vec,
  input logic [NUM_PINS-1:0] edge_vec,
  input logic                route_q,
  input logic [NUM_PINS-1:0] pend_vec,
  input logic [NUM_PINS-1:0] fall_vec,
  input logic [NUM_PINS-1:0] ack_clr
);
  // R3
  mask_gates_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o & ~$past(mask_vec)) == '0);

  // R5
  pend_needs_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_vec & ~$past(pend_vec) & ~$past(fall_vec)) == '0);

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_vec & $past(ack_clr & ~fall_vec)) == '0);

  // R7
  level_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_vec & ~$past(edge_vec)) == '0);

  // R10
  route_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(mc_req_o && req_o[0]));

  // R10
  mc_needs_route_chk: assert property (@(posedge clk) disable iff (rst)
    mc_req_o |-> $past(route_q));
endmodule

bind xirq_sense_unit xirq_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .req_o(req_o), .mc_req_o(mc_req_o),
  .mask_vec(mask_vec), .edge_vec(edge_vec), .route_q(route_q),
  .pend_vec(pend_vec), .fall_vec(fall_vec), .ack_clr(ack_clr)
);

// File: tb/xirq_sense_unit_tb.sv
`timescale 1ns/1ps
module xirq_sense_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin_n = 8'hFF;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  req_o;
  logic        mc_req_o;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  xirq_sense_unit u_dut (
    .clk(clk), .rst(rst), .pin_n(pin_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_o(req_o), .mc_req_o(mc_req_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 req after reset", {24'd0, req_o}, 32'd0);
    check("R1 mc after reset", {31'd0, mc_req_o}, 32'd0);
    rd(2'd1, d); check("R1 mask word", d, 32'd0);
    rd(2'd0, d); check("R1 sense word", d, 32'd0);
    pin_n = 8'h00; idle(5);
    check("R1 all blocked", {24'd0, req_o}, 32'd0);
    pin_n = 8'hFF; idle(4);
  endtask

  task automatic t_sense_map;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d);
    check("R2 sense readback all", d, 32'h0000_FF00);
    wr(2'd0, 32'h0000_8000); rd(2'd0, d);
    check("R2 pin0 at bit15", d, 32'h0000_8000);
    wr(2'd0, 32'h0); wr(2'd1, 32'hFF00_0000); // R3 all pins enabled
  endtask

  task automatic t_level;
    logic [31:0] d;
    pin_n[3] = 1'b0; idle(4);
    check("R4 level low requests", {24'd0, req_o}, 32'h08);
    rd(2'd2, d); check("R3 status bit 28", d, 32'h1000_0000);
    pin_n[3] = 1'b1; idle(4);
    check("R4 level release", {24'd0, req_o}, 32'h0);
  endtask

  task automatic t_ack_level;
    pin_n[5] = 1'b0; idle(4);
    wr(2'd2, 32'hFFFF_FFFF); idle(2);
    check("R7 ack ignored in level", {24'd0, req_o}, 32'h20);
    pin_n[5] = 1'b1; idle(4);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(2'd0, 32'h0000_2000); // R2 pin2 edge
    pin_n[2] = 1'b0; idle(3); pin_n[2] = 1'b1; idle(4);
    check("R5 edge latched", {24'd0, req_o}, 32'h04);
    wr(2'd2, 32'hDFFF_FFFF); idle(2);
    check("R6 zero ack no effect", {24'd0, req_o}, 32'h04);
    wr(2'd2, 32'h2000_0000); idle(2);
    check("R6 ack clears", {24'd0, req_o}, 32'h0);
    rd(2'd2, d); check("R6 status cleared", d, 32'h0);
    wr(2'd0, 32'h0); pin_n[2] = 1'b0; idle(4);
    wr(2'd0, 32'h0000_2000); idle(2);
    pin_n[2] = 1'b1; idle(5);
    check("R5 rising edge ignored", {24'd0, req_o}, 32'h0);
  endtask

  task automatic t_mask_block;
    logic [31:0] d;
    wr(2'd0, 32'h0000_0200); wr(2'd1, 32'h0);
    pin_n[6] = 1'b0; idle(3); pin_n[6] = 1'b1; idle(4);
    check("R8 masked no req", {24'd0, req_o}, 32'h0);
    rd(2'd2, d); check("R8 flag kept", d, 32'h0200_0000);
    wr(2'd1, 32'h0200_0000); idle(2);
    check("R8 unmask shows req", {24'd0, req_o}, 32'h40);
    wr(2'd2, 32'h0200_0000); idle(2);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(2'd0, 32'h0000_4000); wr(2'd1, 32'h4000_0000);
    pin_n[1] = 1'b0; idle(3); pin_n[1] = 1'b1; idle(4);
    @(negedge clk); pin_n[1] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_addr = 2'd2; reg_we = 1'b1; reg_wdata = 32'h4000_0000;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
    pin_n[1] = 1'b1; idle(3);
    check("R9 edge beats ack", {24'd0, req_o}, 32'h02);
    rd(2'd2, d); check("R9 status set", d, 32'h4000_0000);
    wr(2'd2, 32'h4000_0000); idle(2);
  endtask

  task automatic t_route;
    wr(2'd0, 32'h0); wr(2'd1, 32'h8000_0001);
    pin_n[0] = 1'b0; idle(4);
    check("R10 routed mc", {31'd0, mc_req_o}, 32'd1);
    check("R10 routed req0 quiet", {24'd0, req_o}, 32'h0);
    wr(2'd1, 32'h8000_0000); idle(2);
    check("R10 unrouted mc", {31'd0, mc_req_o}, 32'd0);
    check("R10 unrouted req0", {24'd0, req_o}, 32'h01);
    pin_n[0] = 1'b1; idle(4);
  endtask

  initial begin
    idle(3); rst = 1'b0; idle(2);
    t_reset();
    t_sense_map();
    t_level();
    t_ack_level();
    t_edge();
    t_mask_block();
    t_race();
    t_route();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule